// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block receives configuration words over three lines (serial data, serial clock and an active-low frame enable) and keeps them in latch groups that set up a dual frequency synthesizer. A word has 19 bits and is sent most significant bit first. The first 17 bits are the payload. The last two bits are an address that chooses the latch group taking the payload. The groups are: the divider group (swallow count A and main count N), the reference group (reference count R and charge-pump current code) and the control group (detector polarity, two test bits, a port output bit and a power-down bit).

All three serial lines are sampled in the system clock domain. Each line passes through a two-stage synchronizer, and its edges are found one stage later. The serial clock must be slower than the system clock. A rising serial clock edge shifts in one bit, but only while the enable line is low. When the enable line rises, a complete word is moved into its group, and that group gives a strobe one system clock wide. A word with too few bits is dropped. The power-down bit is only an output. It stops neither the shift register nor the latches, so software can still reprogram every group while the synthesizer sleeps.

Top module: `cfg3w_port`

## Requirements
- R1: Bits are taken on rising serial clock edges while enable is low, most significant first. Of the last 19 bits received, the first 17 form the payload (bit 16 arrives first) and the final two form the address (address bit 0 arrives last).
- R2: Address 2'b00 loads div_a from payload[4:0] and div_n from payload[15:5]. Payload bit 16 has no effect on any output.
- R3: Address 2'b01 loads ref_r from payload[10:0] and cp_cur from payload[13:11].
- R4: Address 2'b10 loads the control group: pd_pol from payload bit 0, test_bits from payload[2:1], port_out from payload bit 3 and power_down from payload bit 4.
- R5: Address 2'b11 changes no output register and raises no strobe.
- R6: If enable rises after fewer than 19 accepted serial clock edges, the word is discarded. If more than 19 edges were accepted, only the last 19 bits count.
- R7: Serial clock edges seen while enable is high are neither shifted nor counted toward the next word.
- R8: Each load raises only the strobe of its own group, for exactly one system clock cycle. The strobe and the new register values appear on the third system clock edge after the enable line rises.
- R9: After reset all latched fields are zero, power_down is 1 and all strobes are 0.
- R10: While power_down is 1, words to any group still load normally.
- R11: If an enable rising edge and a serial clock rising edge reach the block in the same system clock cycle, the enable edge wins and that serial clock edge is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock line |
| ser_dat | input | 1 | Serial data line |
| ser_en | input | 1 | Frame enable, low while shifting, rising edge loads |
| div_a | output | 5 | Swallow counter value |
| div_n | output | 11 | Main counter value |
| ref_r | output | 11 | Reference counter value |
| cp_cur | output | 3 | Charge-pump current code |
| pd_pol | output | 1 | Phase detector polarity |
| test_bits | output | 2 | Test control bits |
| port_out | output | 1 | General output port bit |
| power_down | output | 1 | Software power-down request |
| stb_div | output | 1 | One-cycle strobe on divider group update |
| stb_ref | output | 1 | One-cycle strobe on reference group update |
| stb_ctl | output | 1 | One-cycle strobe on control group update |

## Verification
A serial clock rising edge and the enable rising edge can land in the same system clock cycle. The shift-and-count path and the load path then compete. The bench provokes this by driving both lines high at the same instant, at the end of a word with 18 bits and at the end of a word with 19 bits. The 18-bit case must raise no strobe and leave every output unchanged. The 19-bit case must load exactly the 19 bits sent earlier, which shows that the coincident edge was neither shifted in nor allowed to complete the short word.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    localparam int unsigned DATA_W  = 17;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned FRAME_W = DATA_W + ADDR_W;

    // Group selected by the trailing address bits of a word
    typedef enum logic [ADDR_W-1:0] {
        GRP_DIV  = 2'b00,
        GRP_REF  = 2'b01,
        GRP_CTL  = 2'b10,
        GRP_NONE = 2'b11
    } grp_e;

    // Control group; the packed order maps directly onto payload[4:0]
    typedef struct packed {
        logic       pwrdn;   // payload bit 4
        logic       port;    // payload bit 3
        logic [1:0] test;    // payload bits 2:1
        logic       pol;     // payload bit 0
    } ctl_t;

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);

    typedef struct packed {
        logic [STAGES:0][W-1:0] pipe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.pipe[STAGES-1];
    assign prev = st_q.pipe[STAGES];

endmodule

// File: rtl/cfg3w_shifter.sv
module cfg3w_shifter #(
    parameter int unsigned FRAME_W = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    input  logic               clear,
    output logic [FRAME_W-1:0] word,
    output logic               full
);

    localparam int unsigned     CNT_W    = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (shift_en) begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], bit_in};
            if (st_q.cnt != FULL_CNT) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;
    assign full = (st_q.cnt == FULL_CNT);

endmodule

// File: rtl/cfg3w_latches.sv
module cfg3w_latches
    import cfg3w_pkg::*;
#(
    parameter int unsigned A_W  = 5,
    parameter int unsigned N_W  = 11,
    parameter int unsigned R_W  = 11,
    parameter int unsigned CP_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] word,
    output logic [A_W-1:0]     div_a,
    output logic [N_W-1:0]     div_n,
    output logic [R_W-1:0]     ref_r,
    output logic [CP_W-1:0]    cp_cur,
    output ctl_t               ctl,
    output logic [2:0]         stb
);

    localparam int unsigned CTL_W = $bits(ctl_t);

    typedef struct packed {
        logic [A_W-1:0]  a;
        logic [N_W-1:0]  n;
        logic [R_W-1:0]  r;
        logic [CP_W-1:0] cp;
        ctl_t            ctl;
        logic [2:0]      stb;   // [0] divider, [1] reference, [2] control
    } st_t;

    st_t               st_d, st_q;
    logic [DATA_W-1:0] payload;
    grp_e              grp;
    logic              unused_ok;

    assign payload   = word[FRAME_W-1:ADDR_W];
    assign grp       = grp_e'(word[ADDR_W-1:0]);
    assign unused_ok = ^payload;

    always_comb begin
        st_d     = st_q;
        st_d.stb = '0;
        if (load) begin
            case (grp)
                GRP_DIV: begin
                    st_d.a      = payload[A_W-1:0];
                    st_d.n      = payload[A_W+N_W-1:A_W];
                    st_d.stb[0] = 1'b1;
                end
                GRP_REF: begin
                    st_d.r      = payload[R_W-1:0];
                    st_d.cp     = payload[R_W+CP_W-1:R_W];
                    st_d.stb[1] = 1'b1;
                end
                GRP_CTL: begin
                    st_d.ctl    = ctl_t'(payload[CTL_W-1:0]);
                    st_d.stb[2] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.ctl.pwrdn <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_a  = st_q.a;
    assign div_n  = st_q.n;
    assign ref_r  = st_q.r;
    assign cp_cur = st_q.cp;
    assign ctl    = st_q.ctl;
    assign stb    = st_q.stb;

endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port
    import cfg3w_pkg::*;
#(
    parameter int unsigned A_W         = 5,
    parameter int unsigned N_W         = 11,
    parameter int unsigned R_W         = 11,
    parameter int unsigned CP_W        = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_clk,
    input  logic            ser_dat,
    input  logic            ser_en,
    output logic [A_W-1:0]  div_a,
    output logic [N_W-1:0]  div_n,
    output logic [R_W-1:0]  ref_r,
    output logic [CP_W-1:0] cp_cur,
    output logic            pd_pol,
    output logic [1:0]      test_bits,
    output logic            port_out,
    output logic            power_down,
    output logic            stb_div,
    output logic            stb_ref,
    output logic            stb_ctl
);

    localparam int unsigned IDX_CLK = 0;
    localparam int unsigned IDX_DAT = 1;
    localparam int unsigned IDX_EN  = 2;

    logic [2:0]         lines, lvl, prev;
    logic               sclk_rise, en_rise, shift_en, load, frame_full;
    logic               unused_prev;
    logic [FRAME_W-1:0] word;
    logic [2:0]         stb;
    ctl_t               ctl;

    assign lines = {ser_en, ser_dat, ser_clk};

    cfg3w_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lines),
        .lvl  (lvl),
        .prev (prev)
    );

    assign sclk_rise   = lvl[IDX_CLK] & ~prev[IDX_CLK];
    assign en_rise     = lvl[IDX_EN]  & ~prev[IDX_EN];
    assign shift_en    = sclk_rise & ~lvl[IDX_EN];
    assign unused_prev = prev[IDX_DAT];

    cfg3w_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .bit_in  (lvl[IDX_DAT]),
        .clear   (lvl[IDX_EN]),
        .word    (word),
        .full    (frame_full)
    );

    assign load = en_rise & frame_full;

    cfg3w_latches #(.A_W(A_W), .N_W(N_W), .R_W(R_W), .CP_W(CP_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .word  (word),
        .div_a (div_a),
        .div_n (div_n),
        .ref_r (ref_r),
        .cp_cur(cp_cur),
        .ctl   (ctl),
        .stb   (stb)
    );

    assign pd_pol     = ctl.pol;
    assign test_bits  = ctl.test;
    assign port_out   = ctl.port;
    assign power_down = ctl.pwrdn;
    assign stb_div    = stb[0];
    assign stb_ref    = stb[1];
    assign stb_ctl    = stb[2];

endmodule

// File: rtl/cfg3w_port_chk.sv
module cfg3w_port_chk #(
    parameter int unsigned A_W  = 5,
    parameter int unsigned N_W  = 11,
    parameter int unsigned R_W  = 11,
    parameter int unsigned CP_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en_rise,
    input logic            frame_full,
    input logic [A_W-1:0]  div_a,
    input logic [N_W-1:0]  div_n,
    input logic [R_W-1:0]  ref_r,
    input logic [CP_W-1:0] cp_cur,
    input logic            pd_pol,
    input logic [1:0]      test_bits,
    input logic            port_out,
    input logic            power_down,
    input logic            stb_div,
    input logic            stb_ref,
    input logic            stb_ctl
);

    logic stb_any;
    assign stb_any = stb_div | stb_ref | stb_ctl;

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb_div, stb_ref, stb_ctl})); // R8

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb_any |=> !stb_any); // R8

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_div |-> $stable({div_a, div_n})); // R2

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_ref |-> $stable({ref_r, cp_cur})); // R3

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_ctl |-> $stable({pd_pol, test_bits, port_out, power_down})); // R4

    AST_LOAD_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        stb_any |-> $past(en_rise && frame_full)); // R6

endmodule

bind cfg3w_port cfg3w_port_chk #(.A_W(A_W), .N_W(N_W), .R_W(R_W), .CP_W(CP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_rise   (en_rise),
    .frame_full(frame_full),
    .div_a     (div_a),
    .div_n     (div_n),
    .ref_r     (ref_r),
    .cp_cur    (cp_cur),
    .pd_pol    (pd_pol),
    .test_bits (test_bits),
    .port_out  (port_out),
    .power_down(power_down),
    .stb_div   (stb_div),
    .stb_ref   (stb_ref),
    .stb_ctl   (stb_ctl)
);

// File: tb/cfg3w_port_bench.sv
`timescale 1ns/1ps
module cfg3w_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b1;
    logic [4:0]  div_a;
    logic [10:0] div_n, ref_r;
    logic [2:0]  cp_cur;
    logic        pd_pol, port_out, power_down;
    logic [1:0]  test_bits;
    logic        stb_div, stb_ref, stb_ctl;

    int checks = 0, errors = 0;
    bit done = 0;

    // expected model
    logic [4:0]  e_a;
    logic [10:0] e_n, e_r;
    logic [2:0]  e_cp;
    logic [4:0]  e_ctl;   // {pwrdn, port, test[1:0], pol}
    int e_sdiv, e_sref, e_sctl;
    int n_sdiv = 0, n_sref = 0, n_sctl = 0, wide = 0;
    logic p_div = 0, p_ref = 0, p_ctl = 0;

    cfg3w_port u_cfg3w_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .div_a(div_a), .div_n(div_n), .ref_r(ref_r), .cp_cur(cp_cur), .pd_pol(pd_pol),
        .test_bits(test_bits), .port_out(port_out), .power_down(power_down),
        .stb_div(stb_div), .stb_ref(stb_ref), .stb_ctl(stb_ctl)
    );

    always #10 clk = ~clk;

    // strobe monitor: counts pulses and flags any pulse longer than one cycle (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (stb_div) n_sdiv++;
            if (stb_ref) n_sref++;
            if (stb_ctl) n_sctl++;
            if ((stb_div && p_div) || (stb_ref && p_ref) || (stb_ctl && p_ctl)) wide++;
        end
        p_div = stb_div; p_ref = stb_ref; p_ctl = stb_ctl;
    end

    function automatic logic [18:0] mk(input logic [16:0] pl, input logic [1:0] ad);
        return {pl, ad};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input logic [18:0] w);
        logic [16:0] pl;
        pl = w[18:2];
        case (w[1:0])
            2'b00: begin e_a = pl[4:0]; e_n = pl[15:5]; e_sdiv++; end
            2'b01: begin e_r = pl[10:0]; e_cp = pl[13:11]; e_sref++; end
            2'b10: begin e_ctl = pl[4:0]; e_sctl++; end
            default: ;
        endcase
    endtask

    task automatic compare(input string req);
        chk({req, " div"}, {16'd0, e_n, e_a}, {16'd0, div_n, div_a});
        chk({req, " ref"}, {18'd0, e_cp, e_r}, {18'd0, cp_cur, ref_r});
        chk({req, " ctl"}, {27'd0, e_ctl}, {27'd0, power_down, port_out, test_bits, pd_pol});
        chk({req, " strobes"}, {n_sdiv[9:0], n_sref[9:0], n_sctl[9:0]},
                               {e_sdiv[9:0], e_sref[9:0], e_sctl[9:0]});
    endtask

    // sends bits[n-1:0] most significant first, then raises enable
    task automatic send(input logic [31:0] bits, input int n, input bit coincide);
        @(negedge clk) ser_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            @(negedge clk);
        end
        if (coincide) begin
            ser_dat = 1'($urandom);
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            ser_en  = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end else begin
            repeat (2) @(negedge clk);
            ser_en = 1'b1;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(input logic [18:0] w, input string req);
        send({13'd0, w}, 19, 1'b0);
        model(w);
        compare(req);
    endtask

    initial begin
        void'($urandom(32'd2718));
        e_a = '0; e_n = '0; e_r = '0; e_cp = '0; e_ctl = 5'b10000;
        e_sdiv = 0; e_sref = 0; e_sctl = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9 reset state
        compare("R9");
        chk("R9 power_down", {31'd0, power_down}, 32'd1);

        // R1 bit order: only the last payload bit set lands in ref_r bit 0
        frame(mk(17'h00001, 2'b01), "R1");
        chk("R1 ref lsb", {21'd0, ref_r}, 32'd1);

        // R2 extreme values with idle bit set
        frame(mk({1'b1, 11'h7FF, 5'h1F}, 2'b00), "R2");
        frame(mk({1'b1, 11'h000, 5'h00}, 2'b00), "R2 idle bit");

        // R3
        frame(mk({3'b000, 3'b101, 11'h5A3}, 2'b01), "R3");

        // R4 clear power-down and set fields
        frame(mk({12'h000, 5'b01011}, 2'b10), "R4");
        // R10 power-down set, then other groups still load
        frame(mk({12'h000, 5'b10101}, 2'b10), "R10 set");
        frame(mk({1'b0, 11'h3C1, 5'h0A}, 2'b00), "R10 div");
        frame(mk({3'b000, 3'b011, 11'h07E}, 2'b01), "R10 ref");
        chk("R10 power_down", {31'd0, power_down}, 32'd1);

        // R5 unused address
        frame(mk(17'h1FFFF, 2'b11), "R5");

        // R6 short word discarded
        send({14'd0, mk(17'h1ABCD, 2'b00)} >> 1, 18, 1'b0);
        compare("R6 short");
        // R6 long word: leading junk dropped
        send({8'd0, 5'b10110, mk(17'h0F00F, 2'b01)}, 24, 1'b0);
        model(mk(17'h0F00F, 2'b01));
        compare("R6 long");

        // R7 clocks while enable high are ignored, then 10 bits must be dropped
        for (int i = 0; i < 20; i++) begin
            @(negedge clk) ser_clk = 1'b1; ser_dat = 1'($urandom);
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
        send(32'h2AA, 10, 1'b0);
        compare("R7");

        // R11 coincident edges
        send({13'd0, mk(17'h15555, 2'b00)} >> 1, 18, 1'b1);
        compare("R11 18+edge");
        send({13'd0, mk(17'h0AAAA, 2'b01)}, 19, 1'b1);
        model(mk(17'h0AAAA, 2'b01));
        compare("R11 19+edge");

        // random words, lengths and addresses
        for (int k = 0; k < 40; k++) begin
            logic [18:0] w;
            int sel;
            w   = 19'($urandom);
            sel = int'($urandom_range(0, 5));
            if (sel == 0) begin
                int n;
                n = int'($urandom_range(1, 18));
                send({13'd0, w} >> (19 - n), n, 1'b0);
                compare("R6 random short");
            end else if (sel == 1) begin
                logic [4:0] junk;
                junk = 5'($urandom);
                send({8'd0, junk, w}, 24, 1'b0);
                model(w);
                compare("R6 random long");
            end else begin
                frame(w, "R8 random");
            end
        end

        chk("R8 pulse width", wide, 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule